// File: doc/BRIEF.md
# Circulating Serial Word Store

This block models a bit-serial main store whose words circulate past a single read point, in the manner of a delay-line memory. A free-running bit-time counter divides time into word slots of 24 bit times each, and a sector counter common to every line names the slot now passing. Each line presents one word per slot, least significant bit first, followed by its parity bit and a quiet gap bit. The read output always shows the word that the selected line holds in the current slot, so a reader waits for the wanted word to come around instead of addressing it directly.

Lines come in three lengths that share the one sector timing. A full line holds one word per sector value. A short line holds fewer words and repeats them, so its slot index is the sector count modulo its length, which cuts the wait. The index line at address 31 (octal 37) holds a single word that shows up in every sector. Each line's length is fixed by parameters. Line addresses that map to no line read as zero and ignore writes.

A write is armed at the first bit time of a slot in which the selected line's slot index equals the one named by the sector select input. Data arrives serially on the write input during the same slot. The word, with an odd parity bit generated for it, replaces the circulating word at the end of that slot. Parity is checked on every complete read, and a failure sets a flag that stays set until reset.

Top module: `circ_word_store`

## Requirements
- R1: The bit-time counter runs 0 to 23 inside each word slot, and the word strobe is high exactly during bit time 23.
- R2: The sector output is 0 after reset, increments by one as each slot ends, and wraps to 0 after FULL_DEPTH-1. All lines share this one sector count.
- R3: Within a slot the read output carries data bits 0 to 21 at bit times 0 to 21 (least significant first), the parity bit at bit time 22, and 0 at bit time 23.
- R4: A full-length line shows, in each slot, the word whose index equals the sector count.
- R5: A line whose SHORT_MASK bit is set (line 0 by default) holds SHORT_DEPTH words and shows the word whose index is the sector count modulo SHORT_DEPTH.
- R6: Line address 31 is a one-word line that shows the same word in every sector.
- R7: When the write enable is high at bit time 0 of a slot and the selected line's slot index for the current sector equals its slot index for the sector select input, the bits on the write input at bit times 0 to 21 replace that word at the end of the slot. The read output in that slot still shows the old word; the new word appears on its next pass.
- R8: A write changes no word other than the one in its matching slot on its selected line.
- R9: Stored words carry odd parity: after reset every word is zero data with parity bit 1, and every written word gets the parity bit that makes its 23 bits hold an odd number of ones.
- R10: When the line select is held through bit times 0 to 22 of a slot and the 23 bits read hold an even number of ones, the parity error flag sets at the end of bit time 22 and stays set until reset.
- R11: A line address below NUM_LINES or equal to 31 selects a line; any other address reads 0 at every bit time and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sel | input | LINE_W (6) | Address of the line to read or write |
| sector_sel | input | SEC_W | Sector that names the word slot to write |
| wr_en | input | 1 | Write enable, taken at bit time 0 of a slot |
| wr_bit | input | 1 | Serial write data, least significant bit first |
| rd_bit | output | 1 | Serial read data of the selected line |
| cur_sector | output | SEC_W | Sector count of the slot now passing |
| word_strobe | output | 1 | High on the last bit time of each slot |
| parity_err | output | 1 | Sticky odd-parity failure flag |

## Verification
A write and a read of the very same word slot fall in one slot: the write replaces the word at the slot's end while the read output is still shifting out the old copy and the parity check is judging it. The bench provokes this on every random write, since the line it writes is also the line it reads, and in a directed case it then keeps reading a full line for one whole revolution. The old word must come out unchanged in the write slot, and the new word with correct parity must come out on the next pass and not before. A second collision, a parity failure on a line address that holds no line, which also ignores a write in that same slot, is judged by the flag and by the later zero reads.

// File: rtl/circ_store_pkg.sv
package circ_store_pkg;

   localparam int DEF_DATA_W      = 22;
   localparam int DEF_FULL_DEPTH  = 256;
   localparam int DEF_SHORT_DEPTH = 16;
   localparam int DEF_NUM_LINES   = 4;
   localparam int DEF_LINE_W      = 6;
   localparam int DEF_INDEX_LINE  = 31;

   // what the read point is emitting in a given bit time
   typedef enum logic [1:0] {
      PH_DATA   = 2'd0,
      PH_PARITY = 2'd1,
      PH_GAP    = 2'd2
   } bit_phase_e;

endpackage

// File: rtl/circ_timing.sv
module circ_timing #(
   parameter int DATA_W = 22,
   parameter int SEC_W  = 8,
   localparam int SLOT_BITS = DATA_W + 2,
   localparam int PTC_W     = $clog2(SLOT_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [PTC_W-1:0] ptc,
   output logic [SEC_W-1:0] sector,
   output logic             strobe
);

   localparam logic [PTC_W-1:0] LAST_BIT = PTC_W'(SLOT_BITS - 1);
   localparam logic [PTC_W-1:0] PRE_LAST = PTC_W'(SLOT_BITS - 2);

   logic sec_carry;

   if (SLOT_BITS > (1 << PTC_W)) begin : g_bad_ptc
      $error("bit-time counter too narrow for the slot");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptc       <= '0;
         sec_carry <= 1'b0;
         sector    <= '0;
      end else begin
         ptc       <= (ptc == LAST_BIT) ? '0 : ptc + 1'b1;
         // carry is raised one bit time early so the sector steps with the slot edge
         sec_carry <= (ptc == PRE_LAST);
         if (sec_carry) begin
            sector <= sector + 1'b1;
         end
      end
   end

   assign strobe = (ptc == LAST_BIT);

   // R1
   ptc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptc <= LAST_BIT);

   // R2
   carry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_carry |-> (ptc == LAST_BIT));

   // R2
   sector_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (ptc == '0) && (sector == SEC_W'($past(sector) + 1'b1)));

   // R2
   sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && $past(rst_n)) |=> $stable(sector));

endmodule

// File: rtl/circ_line.sv
module circ_line #(
   parameter int DATA_W = 22,
   parameter int DEPTH  = 256,
   parameter int SEC_W  = 8,
   localparam int WORD_W = DATA_W + 1,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEC_W-1:0]  sector,
   input  logic [SEC_W-1:0]  sector_sel,
   input  logic              wr_commit,
   input  logic [WORD_W-1:0] wr_word,
   output logic [WORD_W-1:0] rd_word,
   output logic              slot_hit
);

   localparam logic [WORD_W-1:0] RESET_WORD = {1'b1, {DATA_W{1'b0}}};

   logic [WORD_W-1:0] store [DEPTH];
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  sel_slot;

   if ((DEPTH < 1) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("line depth must be a power of two");
   end
   if (DEPTH > (1 << SEC_W)) begin : g_bad_span
      $error("line longer than the sector count");
   end

   // slot index of a line is the sector modulo its length
   assign idx      = IDX_W'(int'(sector) % DEPTH);
   assign sel_slot = IDX_W'(int'(sector_sel) % DEPTH);
   assign slot_hit = (idx == sel_slot);
   assign rd_word  = store[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            store[i] <= RESET_WORD;
         end
      end else if (wr_commit) begin
         store[idx] <= wr_word;
      end
   end

   // R9
   stored_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^rd_word) == 1'b1);

   // R7
   commit_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |=> (store[$past(idx)] == $past(wr_word)));

endmodule

// File: rtl/circ_wr_capture.sv
module circ_wr_capture #(
   parameter int DATA_W = 22,
   parameter int SEL_W  = 3,
   localparam int WORD_W    = DATA_W + 1,
   localparam int SLOT_BITS = DATA_W + 2,
   localparam int PTC_W     = $clog2(SLOT_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PTC_W-1:0]  ptc,
   input  logic              wr_en,
   input  logic              wr_bit,
   input  logic              sel_ok,
   input  logic              sel_hit,
   input  logic [SEL_W-1:0]  sel_idx,
   output logic              commit,
   output logic [SEL_W-1:0]  commit_idx,
   output logic [WORD_W-1:0] commit_word
);

   localparam logic [PTC_W-1:0] LAST_BIT = PTC_W'(SLOT_BITS - 1);

   logic              armed;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         commit_idx <= '0;
         data_q     <= '0;
      end else begin
         if (ptc == '0) begin
            armed      <= wr_en & sel_ok & sel_hit;
            commit_idx <= sel_idx;
         end else if (ptc == LAST_BIT) begin
            armed <= 1'b0;
         end
         if (int'(ptc) < DATA_W) begin
            data_q[ptc] <= wr_bit;
         end
      end
   end

   assign commit      = armed && (ptc == LAST_BIT);
   assign commit_word = {~(^data_q), data_q};

   // R7
   arm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptc == '0) |-> !armed);

   // R7
   commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !armed);

endmodule

// File: rtl/circ_parity_chk.sv
module circ_parity_chk #(
   parameter int DATA_W = 22,
   parameter int LINE_W = 6,
   localparam int SLOT_BITS = DATA_W + 2,
   localparam int PTC_W     = $clog2(SLOT_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PTC_W-1:0]  ptc,
   input  logic [LINE_W-1:0] line_sel,
   input  logic              rd_bit,
   output logic              parity_err
);

   localparam logic [PTC_W-1:0] PAR_BIT = PTC_W'(DATA_W);

   logic              acc;
   logic              steady;
   logic [LINE_W-1:0] held_line;
   logic              judge;

   assign judge = (ptc == PAR_BIT) && steady && (line_sel == held_line);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc        <= 1'b0;
         steady     <= 1'b0;
         held_line  <= '0;
         parity_err <= 1'b0;
      end else begin
         if (ptc == '0) begin
            acc       <= rd_bit;
            steady    <= 1'b1;
            held_line <= line_sel;
         end else if (ptc <= PAR_BIT) begin
            acc <= acc ^ rd_bit;
            if (line_sel != held_line) begin
               steady <= 1'b0;
            end
         end
         if (judge && !(acc ^ rd_bit)) begin
            parity_err <= 1'b1;
         end
      end
   end

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |=> parity_err);

   // R10
   err_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(parity_err) |-> ($past(ptc) == PAR_BIT));

endmodule

// File: rtl/circ_word_store.sv
module circ_word_store
   import circ_store_pkg::*;
#(
   parameter int DATA_W      = DEF_DATA_W,
   parameter int NUM_LINES   = DEF_NUM_LINES,
   parameter int LINE_W      = DEF_LINE_W,
   parameter int FULL_DEPTH  = DEF_FULL_DEPTH,
   parameter int SHORT_DEPTH = DEF_SHORT_DEPTH,
   parameter int INDEX_LINE  = DEF_INDEX_LINE,
   parameter logic [NUM_LINES-1:0] SHORT_MASK = NUM_LINES'(1),
   localparam int SEC_W = $clog2(FULL_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_sel,
   input  logic [SEC_W-1:0]  sector_sel,
   input  logic              wr_en,
   input  logic              wr_bit,
   output logic              rd_bit,
   output logic [SEC_W-1:0]  cur_sector,
   output logic              word_strobe,
   output logic              parity_err
);

   localparam int WORD_W    = DATA_W + 1;
   localparam int SLOT_BITS = DATA_W + 2;
   localparam int PTC_W     = $clog2(SLOT_BITS);
   localparam int N_SLOTS   = NUM_LINES + 1;
   localparam int SEL_W     = $clog2(N_SLOTS);

   if (INDEX_LINE < NUM_LINES || INDEX_LINE >= (1 << LINE_W)) begin : g_bad_index
      $error("index line address must lie above the ordinary lines");
   end
   if (SHORT_DEPTH > FULL_DEPTH) begin : g_bad_short
      $error("short lines cannot exceed full length");
   end

   logic [PTC_W-1:0]  ptc;
   logic [SEC_W-1:0]  sector;
   logic              sel_ok;
   logic [SEL_W-1:0]  sel_idx;
   logic              sel_hit;
   logic [WORD_W-1:0] sel_word;
   logic [WORD_W-1:0] line_words [N_SLOTS];
   logic [N_SLOTS-1:0] line_hits;
   logic              commit;
   logic [SEL_W-1:0]  commit_idx;
   logic [WORD_W-1:0] commit_word;
   bit_phase_e        phase;

   circ_timing #(
      .DATA_W (DATA_W),
      .SEC_W  (SEC_W)
   ) u_timing (
      .clk    (clk),
      .rst_n  (rst_n),
      .ptc    (ptc),
      .sector (sector),
      .strobe (word_strobe)
   );

   // ordinary lines: each picks full or short length from its mask bit
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      localparam int DEPTH = SHORT_MASK[g] ? SHORT_DEPTH : FULL_DEPTH;
      circ_line #(
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH),
         .SEC_W  (SEC_W)
      ) u_line (
         .clk        (clk),
         .rst_n      (rst_n),
         .sector     (sector),
         .sector_sel (sector_sel),
         .wr_commit  (commit && (commit_idx == SEL_W'(g))),
         .wr_word    (commit_word),
         .rd_word    (line_words[g]),
         .slot_hit   (line_hits[g])
      );
   end

   // the one-word index line occupies the last slot of the line table
   circ_line #(
      .DATA_W (DATA_W),
      .DEPTH  (1),
      .SEC_W  (SEC_W)
   ) u_index_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .sector     (sector),
      .sector_sel (sector_sel),
      .wr_commit  (commit && (commit_idx == SEL_W'(NUM_LINES))),
      .wr_word    (commit_word),
      .rd_word    (line_words[NUM_LINES]),
      .slot_hit   (line_hits[NUM_LINES])
   );

   always_comb begin
      sel_ok  = 1'b0;
      sel_idx = '0;
      if (line_sel == LINE_W'(INDEX_LINE)) begin
         sel_ok  = 1'b1;
         sel_idx = SEL_W'(NUM_LINES);
      end else if (int'(line_sel) < NUM_LINES) begin
         sel_ok  = 1'b1;
         sel_idx = SEL_W'(line_sel);
      end
   end

   assign sel_word = sel_ok ? line_words[sel_idx] : '0;
   assign sel_hit  = sel_ok & line_hits[sel_idx];

   always_comb begin
      if (int'(ptc) < DATA_W) begin
         phase = PH_DATA;
      end else if (int'(ptc) == DATA_W) begin
         phase = PH_PARITY;
      end else begin
         phase = PH_GAP;
      end
      case (phase)
         PH_DATA:   rd_bit = sel_word[ptc];
         PH_PARITY: rd_bit = sel_word[WORD_W-1];
         default:   rd_bit = 1'b0;
      endcase
   end

   circ_wr_capture #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W)
   ) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .ptc         (ptc),
      .wr_en       (wr_en),
      .wr_bit      (wr_bit),
      .sel_ok      (sel_ok),
      .sel_hit     (sel_hit),
      .sel_idx     (sel_idx),
      .commit      (commit),
      .commit_idx  (commit_idx),
      .commit_word (commit_word)
   );

   circ_parity_chk #(
      .DATA_W (DATA_W),
      .LINE_W (LINE_W)
   ) u_par (
      .clk        (clk),
      .rst_n      (rst_n),
      .ptc        (ptc),
      .line_sel   (line_sel),
      .rd_bit     (rd_bit),
      .parity_err (parity_err)
   );

   assign cur_sector = sector;

   // R3
   gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_strobe |-> !rd_bit);

   // R11
   unmapped_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |-> !rd_bit);

   // R6
   index_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_strobe && !commit) |=> $stable(line_words[NUM_LINES]));

endmodule

// File: tb/tb_circ_word_store.sv
module tb_circ_word_store;

   localparam int NL   = 4;
   localparam int LW   = 6;
   localparam int FD   = 32;
   localparam int SD   = 8;
   localparam int DW   = 22;
   localparam int IX   = 31;
   localparam int SLOT = DW + 2;
   localparam int SW   = $clog2(FD);
   localparam logic [NL-1:0] SM = 4'b0101;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [LW-1:0] line_sel;
   logic [SW-1:0] sector_sel;
   logic          wr_en;
   logic          wr_bit;
   logic          rd_bit;
   logic [SW-1:0] cur_sector;
   logic          word_strobe;
   logic          parity_err;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   int unsigned kcnt  = 0;
   bit          done  = 1'b0;

   logic [DW:0] expm [0:NL][0:FD-1];

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) kcnt <= 0;
      else        kcnt <= kcnt + 1;
   end

   circ_word_store #(
      .DATA_W      (DW),
      .NUM_LINES   (NL),
      .LINE_W      (LW),
      .FULL_DEPTH  (FD),
      .SHORT_DEPTH (SD),
      .INDEX_LINE  (IX),
      .SHORT_MASK  (SM)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_sel    (line_sel),
      .sector_sel  (sector_sel),
      .wr_en       (wr_en),
      .wr_bit      (wr_bit),
      .rd_bit      (rd_bit),
      .cur_sector  (cur_sector),
      .word_strobe (word_strobe),
      .parity_err  (parity_err)
   );

   function automatic int map_line(int line);
      if (line == IX) return NL;
      if (line < NL)  return line;
      return -1;
   endfunction

   function automatic int slot_of(int line, int sec);
      if (line == IX) return 0;
      if (line < NL && SM[line]) return sec % SD;
      return sec;
   endfunction

   function automatic logic [DW:0] mkword(logic [DW-1:0] d);
      return {~(^d), d};
   endfunction

   function automatic int now_sec();
      return int'((kcnt / SLOT) % FD);
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // one word slot, entered at a negedge where the bit-time count is 0
   task automatic run_slot(int line, bit we, int tsec, logic [DW-1:0] data, string tag);
      int          sec = now_sec();
      int          m   = map_line(line);
      logic [SLOT-1:0] got = '0;
      logic [SLOT-1:0] expw;
      bit          strobe_ok = 1'b1;
      bit          sec_ok    = 1'b1;
      line_sel   = LW'(line);
      wr_en      = we;
      sector_sel = SW'(tsec);
      for (int b = 0; b < SLOT; b++) begin
         wr_bit = (b < DW) ? data[b] : 1'b0;
         #1;
         got[b] = rd_bit;
         if (word_strobe !== (b == SLOT - 1)) strobe_ok = 1'b0;
         if (int'(cur_sector) != sec) sec_ok = 1'b0;
         @(negedge clk);
      end
      wr_en = 1'b0;
      expw = (m >= 0) ? {1'b0, expm[m][slot_of(line, sec)]} : '0;
      check(strobe_ok, "R1 strobe", 32'(word_strobe), 32'(1));
      check(sec_ok, "R2 sector", 32'(cur_sector), 32'(sec));
      check(got[SLOT-1] == 1'b0, "R3 gap", 32'(got[SLOT-1]), 32'(0));
      check(got == expw, tag, 32'(got), 32'(expw));
      if (we && m >= 0 && slot_of(line, sec) == slot_of(line, tsec)) begin
         expm[m][slot_of(line, sec)] = mkword(data);
      end
   endtask

   function automatic string tag_of(int line);
      if (line == IX) return "R6 index line";
      if (SM[line])   return "R5 short line";
      return "R4 full line";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", kcnt, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      int s;
      void'($urandom(32'h5eed_2024));
      for (int l = 0; l <= NL; l++)
         for (int i = 0; i < FD; i++)
            expm[l][i] = {1'b1, {DW{1'b0}}};
      rst_n = 1'b0; line_sel = '0; sector_sel = '0; wr_en = 1'b0; wr_bit = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(cur_sector == '0, "R2 reset sector", 32'(cur_sector), 32'(0));
      check(word_strobe == 1'b0, "R1 reset strobe", 32'(word_strobe), 32'(0));
      check(parity_err == 1'b0, "R10 reset flag", 32'(parity_err), 32'(0));
      check(rd_bit == 1'b0, "R3 reset bit0", 32'(rd_bit), 32'(0));
      @(negedge clk);
      while (kcnt % SLOT != 0) @(negedge clk);

      // R9 reset contents: zero data, parity one
      run_slot(1, 1'b0, 0, '0, "R9 reset word");

      // R6 index write, then seen in later sectors
      d = 22'h2A5F31;
      run_slot(IX, 1'b1, 0, d, "R6 index old");
      run_slot(IX, 1'b0, 0, '0, "R6 index new");
      run_slot(IX, 1'b0, 0, '0, "R6 index again");

      // R7 write and read of the same slot, then a full revolution
      d = 22'h13C0DE;
      s = now_sec();
      run_slot(1, 1'b1, s, d, "R7 old word in write slot");
      for (int i = 1; i < FD; i++) run_slot(1, 1'b0, 0, '0, "R8 untouched slot");
      run_slot(1, 1'b0, 0, '0, "R7 new word next pass");
      check(((^mkword(d)) == 1'b1), "R9 odd parity", 32'(mkword(d)), 32'(mkword(d)));

      // R5 short line write reappears every SD slots
      d = 22'h0F0F0F;
      s = now_sec();
      run_slot(0, 1'b1, s + SD, d, "R5 short write slot");
      for (int i = 1; i <= SD; i++) run_slot(0, 1'b0, 0, '0, "R5 short line");

      // R7 no match: write must not land
      s = now_sec();
      run_slot(3, 1'b1, (s + 5) % FD, 22'h3FFFFF, "R7 miss slot");
      for (int i = 1; i < FD; i++) run_slot(3, 1'b0, 0, '0, "R8 miss revolution");

      // random mix over populated lines
      for (int i = 0; i < 300; i++) begin
         int r  = int'($urandom % 5);
         int ln = (r == 4) ? IX : r;
         bit we = $urandom % 2;
         int ts = ($urandom % 2) ? now_sec() : int'($urandom % FD);
         run_slot(ln, we, ts, DW'($urandom), tag_of(ln));
      end
      check(parity_err == 1'b0, "R10 clean reads", 32'(parity_err), 32'(0));

      // R11 unmapped line: reads zero, write ignored, parity fails
      s = now_sec();
      run_slot(5, 1'b1, s, 22'h155555, "R11 unmapped read");
      check(parity_err == 1'b1, "R10 flag on even word", 32'(parity_err), 32'(1));
      run_slot(5, 1'b0, 0, '0, "R11 write ignored");
      for (int i = 0; i < 8; i++) run_slot(i % NL, 1'b0, 0, '0, "R8 after unmapped");
      check(parity_err == 1'b1, "R10 flag sticky", 32'(parity_err), 32'(1));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule